// File: doc/BRIEF.md
# Replicated Multi-Read-Port Register File

This block is a register file with a single write port and a parameterised number of independent read ports. It obtains the extra read ports by keeping one synchronous memory bank per read port. All banks share the write side: each write goes to the same address with the same data in every bank, so every copy holds the same contents. Each bank's second port serves exactly one read port, with a registered address and registered read data.

A bank cannot return a sensible value for a location that is being written in the same cycle. A forwarding path covers that case. A controller compares every read address with the write address while a write is active, and registers one select bit per port. The datapath keeps a registered copy of the write data. When a port's select is set, that port returns the forwarded word instead of the bank output. This gives read-after-write inside one cycle. Write-after-read ordering is not provided.

Top module: `multiReadRegFile`

## Requirements
- R1: A write with `wrEn` high stores `wrData` at `wrAddr` in every bank, so any read port that later reads that address returns the word.
- R2: With no write to the addressed location, a read port returns the stored word on `rdData` after the first rising edge at which its address is sampled (one cycle of latency).
- R3: When a port's read address equals `wrAddr` with `wrEn` high at the same edge, that port returns the new `wrData` after that edge, never the previous contents. This holds on every port.
- R4: Read ports are independent. Port p uses address bits `[p*AW +: AW]` of `rdAddr` and drives data bits `[p*WIDTH +: WIDTH]` of `rdData`. Different ports may read different addresses in the same cycle.
- R5: With `wrEn` low, `wrAddr` and `wrData` have no effect on the stored contents.
- R6: Reset (`rstN` low, asynchronous) clears only the forwarding selects. Stored words survive reset and are read back correctly afterwards.
- R7: During a collision, ports whose address differs from `wrAddr` still return the stored word at their own address.
- R8: With `wrEn` low, a read address equal to `wrAddr` does not forward. The port returns the stored word.
- R9: When two writes to one address occur on consecutive edges, a read presented at the edge after the second write returns the second word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the forwarding selects |
| wrEn | input | 1 | Write enable |
| wrAddr | input | AW | Write address |
| wrData | input | WIDTH | Write data |
| rdAddr | input | NUM_RD*AW | Packed read addresses, port p at bits [p*AW +: AW] |
| rdData | output | NUM_RD*WIDTH | Packed read data, port p at bits [p*WIDTH +: WIDTH] |

## Verification
The bench builds the block with four read ports, 32 words of 16 bits. With only 32 locations, biased random addresses collide with the write address often, on single ports and on several ports in one cycle. This exercises the forwarding select on each replica, and mixes forwarded and stored results in the same cycle. Directed phases add non-forwarding address matches with the write disabled, back-to-back writes to one location, and a reset in the middle of traffic followed by full read-back.

// File: rtl/rfRep_pkg.sv
package rfRep_pkg;
  localparam int MAX_RD = 8;

  typedef struct packed {
    logic capWr;   // capture write data for forwarding
  } rfStrb_t;
endpackage

// File: rtl/rfRepBank.sv
module rfRepBank #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] mem [DEPTH];

  // write port and read port share a clock; collision result is unusable
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    rdData <= mem[rdAddr];
  end

  // a word written two edges back, read at the next edge without a new collision, comes out intact
  assert_stored_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn, 2) && ($past(wrAddr, 2) == $past(rdAddr)) &&
     !($past(wrEn) && ($past(wrAddr) == $past(rdAddr))))
    |-> (rdData == $past(wrData, 2)));
endmodule

// File: rtl/rfRepCtrl.sv
module rfRepCtrl
  import rfRep_pkg::*;
#(
  parameter int NUM_RD = 4,
  parameter int AW = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [AW-1:0]        wrAddr,
  input  logic [NUM_RD*AW-1:0] rdAddr,
  output logic [NUM_RD-1:0]    bypSel,
  output rfStrb_t              strb
);
  logic [NUM_RD-1:0] hit;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_cmp
    assign hit[p] = wrEn && (rdAddr[p*AW +: AW] == wrAddr);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bypSel[p] <= 1'b0;
      else       bypSel[p] <= hit[p];
    end

    // forwarding can only follow an active write
    assert_fwd_needs_wr_R8: assert property (@(posedge clk) disable iff (!rstN)
      bypSel[p] |-> $past(wrEn));
  end

  always_comb begin
    strb.capWr = |hit;
  end
endmodule

// File: rtl/rfRepDatapath.sv
module rfRepDatapath
  import rfRep_pkg::*;
#(
  parameter int NUM_RD = 4,
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [AW-1:0]           wrAddr,
  input  logic [WIDTH-1:0]        wrData,
  input  logic [NUM_RD*AW-1:0]    rdAddr,
  input  logic [NUM_RD-1:0]       bypSel,
  input  rfStrb_t                 strb,
  output logic [NUM_RD*WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] wrDataQ;
  logic [WIDTH-1:0] bankOut [NUM_RD];

  always_ff @(posedge clk) begin
    if (strb.capWr) wrDataQ <= wrData;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    rfRepBank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (wrEn),
      .wrAddr (wrAddr),
      .wrData (wrData),
      .rdAddr (rdAddr[p*AW +: AW]),
      .rdData (bankOut[p])
    );

    assign rdData[p*WIDTH +: WIDTH] = bypSel[p] ? wrDataQ : bankOut[p];

    // a forwarded port shows the word written at the previous edge
    assert_fwd_data_R3: assert property (@(posedge clk) disable iff (!rstN)
      bypSel[p] |-> (rdData[p*WIDTH +: WIDTH] == $past(wrData)));

    // replicas agree: equal addresses at one edge give equal data
    if (p > 0) begin : g_rep
      assert_replica_R4: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rdAddr[p*AW +: AW]) == $past(rdAddr[0 +: AW]))
        |-> (rdData[p*WIDTH +: WIDTH] == rdData[0 +: WIDTH]));
    end
  end
endmodule

// File: rtl/multiReadRegFile.sv
module multiReadRegFile
  import rfRep_pkg::*;
#(
  parameter int NUM_RD = 4,
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [AW-1:0]           wrAddr,
  input  logic [WIDTH-1:0]        wrData,
  input  logic [NUM_RD*AW-1:0]    rdAddr,
  output logic [NUM_RD*WIDTH-1:0] rdData
);
  logic [NUM_RD-1:0] bypSel;
  rfStrb_t           strb;

  rfRepCtrl #(.NUM_RD(NUM_RD), .AW(AW)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .bypSel (bypSel),
    .strb   (strb)
  );

  rfRepDatapath #(.NUM_RD(NUM_RD), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .bypSel (bypSel),
    .strb   (strb),
    .rdData (rdData)
  );
endmodule

// File: tb/multiReadRegFile_tb.sv
module multiReadRegFile_tb;
  localparam int NRD = 4;
  localparam int DEP = 32;
  localparam int DW  = 16;
  localparam int AW  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [NRD*AW-1:0] rdAddr = '0;
  logic [NRD*DW-1:0] rdData;

  always #2 clk = ~clk;

  multiReadRegFile #(.NUM_RD(NRD), .DEPTH(DEP), .WIDTH(DW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  logic [DW-1:0] refMem [DEP];
  bit refVal [DEP];
  string phaseTag = "R2";

  always @(posedge clk) cycles <= cycles + 1;

  // one clock: reference computed at the edge, outputs compared half a period later
  task automatic step();
    logic [DW-1:0] expd [NRD];
    bit expOk [NRD];
    string tag [NRD];
    @(posedge clk);
    for (int p = 0; p < NRD; p++) begin
      logic [AW-1:0] ra = rdAddr[p*AW +: AW];
      if (wrEn && ra == wrAddr) begin
        expd[p] = wrData; expOk[p] = 1; tag[p] = "R3";
      end else begin
        expd[p] = refMem[ra]; expOk[p] = refVal[ra];
        if (!wrEn && ra == wrAddr) tag[p] = "R8";
        else if (wrEn) tag[p] = "R7";
        else tag[p] = phaseTag;
      end
    end
    if (wrEn) begin refMem[wrAddr] = wrData; refVal[wrAddr] = 1; end
    @(negedge clk);
    for (int p = 0; p < NRD; p++) begin
      if (expOk[p]) begin
        checks++;
        if (rdData[p*DW +: DW] !== expd[p]) begin
          errs++;
          $display("FAIL %s port %0d: actual=%h expected=%h", tag[p], p,
                   rdData[p*DW +: DW], expd[p]);
        end
      end
    end
  endtask

  task automatic setRd(int p, logic [AW-1:0] a);
    rdAddr[p*AW +: AW] = a;
  endtask

  initial begin
    for (int i = 0; i < DEP; i++) refVal[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: fill every word
    phaseTag = "R1";
    for (int i = 0; i < DEP; i++) begin
      wrEn = 1; wrAddr = AW'(i); wrData = DW'(16'hA500 ^ (i * 16'h0123));
      for (int p = 0; p < NRD; p++) setRd(p, AW'((i + 1 + p) % DEP));
      step();
    end
    wrEn = 0;

    // R2/R4: read all words, ports on different addresses
    phaseTag = "R4";
    for (int i = 0; i < DEP; i++) begin
      for (int p = 0; p < NRD; p++) setRd(p, AW'((i + p * 7) % DEP));
      step();
    end

    // R5/R8: write disabled, matching addresses and junk data
    phaseTag = "R5";
    for (int i = 0; i < 16; i++) begin
      wrEn = 0; wrAddr = AW'(i); wrData = 16'hDEAD;
      for (int p = 0; p < NRD; p++) setRd(p, AW'(i));
      step();
    end
    for (int i = 0; i < DEP; i++) begin
      for (int p = 0; p < NRD; p++) setRd(p, AW'(i));
      step();
    end

    // R3/R7: random traffic with forced collisions
    phaseTag = "R2";
    for (int i = 0; i < 600; i++) begin
      wrEn = ($urandom_range(0, 3) != 0);
      wrAddr = AW'($urandom_range(0, DEP - 1));
      wrData = DW'($urandom);
      for (int p = 0; p < NRD; p++)
        setRd(p, ($urandom_range(0, 2) == 0) ? wrAddr : AW'($urandom_range(0, DEP - 1)));
      step();
    end

    // R9: back-to-back writes to one address, then read
    phaseTag = "R9";
    for (int k = 0; k < 4; k++) begin
      wrEn = 1; wrAddr = AW'(5 + k); wrData = 16'h1111 * DW'(k + 1);
      for (int p = 0; p < NRD; p++) setRd(p, AW'(20));
      step();
      wrData = 16'hC0DE ^ DW'(k);
      step();
      wrEn = 0;
      for (int p = 0; p < NRD; p++) setRd(p, AW'(5 + k));
      step();
    end

    // R6: reset in the middle, contents must survive
    wrEn = 0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    phaseTag = "R6";
    for (int i = 0; i < DEP; i++) begin
      for (int p = 0; p < NRD; p++) setRd(p, AW'((i + p) % DEP));
      step();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errs++;
    $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule